// File: doc/BRIEF.md
# Serial EEPROM Page-Write Controller

This block takes the byte-level events of a two-wire serial EEPROM and turns a page write into programming of the memory array. A front end that already decodes the bus hands it a start event, a stop event, and each received byte at the point where that byte is acknowledged. The front end also supplies a flag that says whether the device-select part of the command byte matches this device. The controller reads the command byte and two address bytes. It then collects up to one page of data bytes into a local buffer and marks each buffer slot it loads.

When the stop arrives, the controller runs a programming cycle of fixed length on a plain write port into the array. The first phase writes all-ones to every loaded slot of the addressed page. The second phase writes the buffered values into the same slots. Slots that were not loaded see no write in either phase. The phase lengths are parameters. A busy output covers the whole cycle, and during that time the controller acknowledges nothing.

Top module: `pagewr_ctrl`

## Requirements
- R1: `ack` is high only in a cycle where `rx_valid` is high. The command byte is acknowledged only when `dev_match` is high and byte bit 0 is 0 (write). Any other command byte is not acknowledged, and no later byte is acknowledged until the next start.
- R2: The array address is formed from bits 4:0 of the first address byte as A12..A8 and the whole second address byte as A7..A0. Bits 7:5 of the first address byte are ignored. The first data byte is written to this address.
- R3: Each acknowledged data byte moves the write position up by one in address bits 4:0 only. Bits 12:5 stay fixed for the whole transaction and for its programming cycle.
- R4: Past the last byte of the 32-byte page, the position wraps to offset 0 of the same page. A later byte that lands on an already loaded offset replaces the earlier value.
- R5: A stop after at least one data byte raises `busy` in the next cycle. `busy` then stays high for exactly ERASE_CYC + WRITE_CYC cycles.
- R6: In the first 32 cycles of the erase phase, cycle k drives `mem_we` with data 8'hFF at page offset k if offset k was loaded. The write phase does the same with the buffered byte. In the remaining phase cycles and outside the busy window, `mem_we` is low.
- R7: A page offset that no data byte addressed is never written.
- R8: A read command (bit 0 = 1), or a stop that comes before any data byte, starts no programming cycle.
- R9: While `busy` is high, no byte is acknowledged and start, stop and received bytes have no effect.
- R10: A start clears the record of loaded offsets, so a restart in mid-transaction discards the bytes received so far.
- R11: After reset `busy`, `ack` and `mem_we` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_start | input | 1 | Start event, one-cycle pulse |
| bus_stop | input | 1 | Stop event, one-cycle pulse |
| rx_valid | input | 1 | A received byte is at its acknowledge point |
| rx_byte | input | 8 | Received byte |
| dev_match | input | 1 | Device-select bits of the current byte match |
| ack | output | 1 | Acknowledge for the byte in this cycle |
| busy | output | 1 | Programming cycle in progress |
| mem_we | output | 1 | Array write strobe |
| mem_addr | output | ADDR_W | Array byte address |
| mem_wdata | output | 8 | Array write data |

## Verification
The bench targets a start address near the page end and a 34-byte burst. A controller that carries into bit 5 would spill into the next page, and one that keeps the first value would leave stale bytes at offsets 0 and 1. The bench records the first value written to each address, so skipping the erase phase or erasing unloaded neighbours shows up in the array image. Read commands, a stop with no data, a non-matching device and a restart in mid-transaction must each leave the array untouched or discard the old bytes. A full transaction sent during busy must get no acknowledge and must not add a second programming cycle.

// File: rtl/pw_pkg.sv
package pw_pkg;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_CMD,
        RX_AHI,
        RX_ALO,
        RX_DATA
    } rx_state_e;

    typedef enum logic [1:0] {
        PG_IDLE,
        PG_ERASE,
        PG_WRITE
    } pg_state_e;

endpackage

// File: rtl/pw_rx_parser.sv
module pw_rx_parser #(
    parameter int ADDR_W     = 13,
    parameter int PAGE_BYTES = 32,
    parameter int OFS_W      = $clog2(PAGE_BYTES),
    parameter int PAGE_W     = ADDR_W - OFS_W
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          bus_start,
    input  logic                          bus_stop,
    input  logic                          rx_valid,
    input  logic [7:0]                    rx_byte,
    input  logic                          dev_match,
    input  logic                          busy,
    output logic                          ack,
    output logic                          go_prog,
    output logic [PAGE_W-1:0]             page_addr,
    output logic [PAGE_BYTES-1:0]         load_mask,
    output logic [PAGE_BYTES-1:0][7:0]    page_buf
);
    import pw_pkg::*;

    typedef struct packed {
        rx_state_e                       st;
        logic [ADDR_W-1:0]               addr;
        logic [PAGE_BYTES-1:0]           mask;
        logic [PAGE_BYTES-1:0][7:0]      data;
    } rx_regs_t;

    rx_regs_t rx_q, rx_d;
    logic [OFS_W-1:0] ofs;

    assign ofs = rx_q.addr[OFS_W-1:0];

    always_comb begin
        rx_d    = rx_q;
        ack     = 1'b0;
        go_prog = 1'b0;
        if (!busy) begin
            if (bus_start) begin
                rx_d.st   = RX_CMD;
                rx_d.mask = '0;
            end else if (bus_stop) begin
                go_prog = (rx_q.st == RX_DATA) && (|rx_q.mask);
                rx_d.st = RX_IDLE;
            end else if (rx_valid) begin
                case (rx_q.st)
                    RX_CMD: begin
                        if (dev_match && !rx_byte[0]) begin
                            ack     = 1'b1;
                            rx_d.st = RX_AHI;
                        end else begin
                            rx_d.st = RX_IDLE;
                        end
                    end
                    RX_AHI: begin
                        ack = 1'b1;
                        rx_d.addr[ADDR_W-1:8] = rx_byte[ADDR_W-9:0];
                        rx_d.st = RX_ALO;
                    end
                    RX_ALO: begin
                        ack = 1'b1;
                        rx_d.addr[7:0] = rx_byte;
                        rx_d.st = RX_DATA;
                    end
                    RX_DATA: begin
                        ack = 1'b1;
                        rx_d.data[ofs] = rx_byte;
                        rx_d.mask[ofs] = 1'b1;
                        rx_d.addr[OFS_W-1:0] = ofs + 1'b1;
                    end
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rx_q <= '0;
        else        rx_q <= rx_d;
    end

    assign page_addr = rx_q.addr[ADDR_W-1:OFS_W];
    assign load_mask = rx_q.mask;
    assign page_buf  = rx_q.data;

endmodule

// File: rtl/pw_prog_seq.sv
module pw_prog_seq #(
    parameter int ADDR_W     = 13,
    parameter int PAGE_BYTES = 32,
    parameter int ERASE_CYC  = 40,
    parameter int WRITE_CYC  = 40,
    parameter int OFS_W      = $clog2(PAGE_BYTES),
    parameter int PAGE_W     = ADDR_W - OFS_W
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          go_prog,
    input  logic [PAGE_W-1:0]             page_addr,
    input  logic [PAGE_BYTES-1:0]         load_mask,
    input  logic [PAGE_BYTES-1:0][7:0]    page_buf,
    output logic                          busy,
    output logic                          mem_we,
    output logic [ADDR_W-1:0]             mem_addr,
    output logic [7:0]                    mem_wdata
);
    import pw_pkg::*;

    // Both phases must be at least one page long so every slot gets its turn.
    localparam int CYC_MAX = (ERASE_CYC > WRITE_CYC) ? ERASE_CYC : WRITE_CYC;
    localparam int CNT_W   = $clog2(CYC_MAX + 1);
    localparam logic [CNT_W-1:0] ERASE_LAST = CNT_W'(ERASE_CYC - 1);
    localparam logic [CNT_W-1:0] WRITE_LAST = CNT_W'(WRITE_CYC - 1);
    localparam logic [CNT_W-1:0] SLOT_LIM   = CNT_W'(PAGE_BYTES);

    typedef struct packed {
        pg_state_e        st;
        logic [CNT_W-1:0] cnt;
    } pg_regs_t;

    pg_regs_t pg_q, pg_d;
    logic [OFS_W-1:0] slot;
    logic             in_window;

    always_comb begin
        pg_d = pg_q;
        case (pg_q.st)
            PG_IDLE: begin
                if (go_prog) begin
                    pg_d.st  = PG_ERASE;
                    pg_d.cnt = '0;
                end
            end
            PG_ERASE: begin
                if (pg_q.cnt == ERASE_LAST) begin
                    pg_d.st  = PG_WRITE;
                    pg_d.cnt = '0;
                end else begin
                    pg_d.cnt = pg_q.cnt + 1'b1;
                end
            end
            PG_WRITE: begin
                if (pg_q.cnt == WRITE_LAST) begin
                    pg_d.st  = PG_IDLE;
                    pg_d.cnt = '0;
                end else begin
                    pg_d.cnt = pg_q.cnt + 1'b1;
                end
            end
            default: pg_d = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pg_q <= '0;
        else        pg_q <= pg_d;
    end

    assign busy      = (pg_q.st != PG_IDLE);
    assign slot      = pg_q.cnt[OFS_W-1:0];
    assign in_window = busy && (pg_q.cnt < SLOT_LIM);
    assign mem_we    = in_window && load_mask[slot];
    assign mem_addr  = {page_addr, slot};
    assign mem_wdata = (pg_q.st == PG_ERASE) ? 8'hFF : page_buf[slot];

endmodule

// File: rtl/pagewr_ctrl.sv
module pagewr_ctrl #(
    parameter int ADDR_W     = 13,
    parameter int PAGE_BYTES = 32,
    parameter int ERASE_CYC  = 40,
    parameter int WRITE_CYC  = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_start,
    input  logic              bus_stop,
    input  logic              rx_valid,
    input  logic [7:0]        rx_byte,
    input  logic              dev_match,
    output logic              ack,
    output logic              busy,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata
);
    localparam int OFS_W  = $clog2(PAGE_BYTES);
    localparam int PAGE_W = ADDR_W - OFS_W;

    logic                       go_prog;
    logic [PAGE_W-1:0]          page_addr;
    logic [PAGE_BYTES-1:0]      load_mask;
    logic [PAGE_BYTES-1:0][7:0] page_buf;

    pw_rx_parser #(
        .ADDR_W    (ADDR_W),
        .PAGE_BYTES(PAGE_BYTES)
    ) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_start (bus_start),
        .bus_stop  (bus_stop),
        .rx_valid  (rx_valid),
        .rx_byte   (rx_byte),
        .dev_match (dev_match),
        .busy      (busy),
        .ack       (ack),
        .go_prog   (go_prog),
        .page_addr (page_addr),
        .load_mask (load_mask),
        .page_buf  (page_buf)
    );

    pw_prog_seq #(
        .ADDR_W    (ADDR_W),
        .PAGE_BYTES(PAGE_BYTES),
        .ERASE_CYC (ERASE_CYC),
        .WRITE_CYC (WRITE_CYC)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .go_prog   (go_prog),
        .page_addr (page_addr),
        .load_mask (load_mask),
        .page_buf  (page_buf),
        .busy      (busy),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata)
    );

endmodule

// File: rtl/pagewr_ctrl_chk.sv
module pagewr_ctrl_chk #(
    parameter int PAGE_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_stop,
    input logic              rx_valid,
    input logic              ack,
    input logic              busy,
    input logic              mem_we,
    input logic [PAGE_W-1:0] page_bits
);

    AST_ACK_NEEDS_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> rx_valid); // R1

    AST_NO_ACK_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !ack); // R9

    AST_BUSY_FROM_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(bus_stop)); // R5

    AST_WE_IN_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> busy); // R6

    AST_PAGE_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(page_bits)); // R3

endmodule

bind pagewr_ctrl pagewr_ctrl_chk #(
    .PAGE_W(ADDR_W - $clog2(PAGE_BYTES))
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_stop  (bus_stop),
    .rx_valid  (rx_valid),
    .ack       (ack),
    .busy      (busy),
    .mem_we    (mem_we),
    .page_bits (mem_addr[ADDR_W-1:$clog2(PAGE_BYTES)])
);

// File: tb/pagewr_ctrl_bench.sv
`timescale 1ns/1ps
module pagewr_ctrl_bench;
    localparam int ERASE_CYC = 40;
    localparam int WRITE_CYC = 40;
    localparam int PAGE      = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_start = 1'b0, bus_stop = 1'b0, rx_valid = 1'b0, dev_match = 1'b1;
    logic [7:0] rx_byte = 8'h00;
    logic ack, busy, mem_we;
    logic [12:0] mem_addr;
    logic [7:0] mem_wdata;

    always #2.5 clk = ~clk;

    pagewr_ctrl #(.ERASE_CYC(ERASE_CYC), .WRITE_CYC(WRITE_CYC)) u_pagewr_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_start(bus_start), .bus_stop(bus_stop),
        .rx_valid(rx_valid), .rx_byte(rx_byte), .dev_match(dev_match),
        .ack(ack), .busy(busy), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata)
    );

    int n_chk = 0, n_fail = 0;

    // behavioural reference model state
    int m_st = 0, m_hi = 0, m_page = 0, m_ofs = 0, m_phase = 0, m_cnt = 0;
    bit [31:0] m_mask = '0;
    byte unsigned m_buf[32];

    // observed array image and trackers
    byte unsigned dut_mem[int];
    byte unsigned dut_first[int];
    bit seen_ack, seen_busy;
    int busy_cnt;

    task automatic check(bit ok, string req, string what, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic cyc(bit s, bit p, bit v, byte unsigned b);
        bit e_busy, e_ack, e_we;
        int e_addr, e_data;
        @(negedge clk);
        bus_start = s; bus_stop = p; rx_valid = v; rx_byte = b;
        #1;
        e_busy = (m_phase != 0);
        e_ack  = !e_busy && !s && !p && v &&
                 ((m_st == 1 && dev_match && !b[0]) || (m_st inside {2, 3, 4}));
        e_we   = e_busy && (m_cnt < PAGE) && m_mask[m_cnt % PAGE];
        e_addr = m_page * PAGE + (m_cnt % PAGE);
        e_data = (m_phase == 1) ? 8'hFF : m_buf[m_cnt % PAGE];
        check(ack == e_ack, "R1", "ack", ack, e_ack);
        check(busy == e_busy, "R5", "busy", busy, e_busy);
        check(mem_we == e_we, "R6", "mem_we", mem_we, e_we);
        if (e_we) begin
            check(mem_addr == e_addr, "R3", "mem_addr", mem_addr, e_addr);
            check(mem_wdata == e_data, "R6", "mem_wdata", mem_wdata, e_data);
        end
        if (ack) seen_ack = 1'b1;
        if (busy) begin seen_busy = 1'b1; busy_cnt++; end
        if (mem_we) begin
            if (!dut_first.exists(int'(mem_addr))) dut_first[int'(mem_addr)] = mem_wdata;
            dut_mem[int'(mem_addr)] = mem_wdata;
        end
        // advance the model across the coming edge
        if (e_busy) begin
            m_cnt++;
            if (m_phase == 1 && m_cnt == ERASE_CYC) begin m_phase = 2; m_cnt = 0; end
            else if (m_phase == 2 && m_cnt == WRITE_CYC) begin m_phase = 0; m_cnt = 0; end
        end else if (s) begin
            m_st = 1; m_mask = '0;
        end else if (p) begin
            if (m_st == 4 && m_mask != 0) begin m_phase = 1; m_cnt = 0; end
            m_st = 0;
        end else if (v) begin
            case (m_st)
                1: m_st = (dev_match && !b[0]) ? 2 : 0;
                2: begin m_hi = b % 32; m_st = 3; end
                3: begin m_page = m_hi * 8 + b / 32; m_ofs = b % 32; m_st = 4; end
                4: begin m_buf[m_ofs] = b; m_mask[m_ofs] = 1'b1; m_ofs = (m_ofs + 1) % PAGE; end
                default: ;
            endcase
        end
    endtask

    task automatic send(byte unsigned b);
        cyc(0, 0, 1, b);
        cyc(0, 0, 0, 8'h00);
    endtask

    task automatic clr();
        dut_mem.delete(); dut_first.delete();
        seen_ack = 0; seen_busy = 0; busy_cnt = 0;
    endtask

    task automatic wait_done();
        cyc(0, 0, 0, 8'h00);
        while (m_phase != 0) cyc(0, 0, 0, 8'h00);
        cyc(0, 0, 0, 8'h00);
        cyc(0, 0, 0, 8'h00);
    endtask

    task automatic head(byte unsigned cmd, byte unsigned hi, byte unsigned lo);
        cyc(1, 0, 0, 8'h00);
        send(cmd); send(hi); send(lo);
    endtask

    task automatic chk_mem(int a, int exp, string req);
        if (exp < 0)
            check(!dut_mem.exists(a), req, $sformatf("addr %0h untouched", a),
                  dut_mem.exists(a) ? dut_mem[a] : -1, -1);
        else begin
            check(dut_mem.exists(a) && dut_mem[a] == exp, req,
                  $sformatf("addr %0h value", a), dut_mem.exists(a) ? dut_mem[a] : -1, exp);
            check(dut_first.exists(a) && dut_first[a] == 8'hFF, "R6",
                  $sformatf("addr %0h erased first", a),
                  dut_first.exists(a) ? dut_first[a] : -1, 8'hFF);
        end
    endtask

    task automatic run_all();
        // R11: reset state
        repeat (3) @(negedge clk);
        #1;
        check(busy == 0, "R11", "busy in reset", busy, 0);
        check(ack == 0, "R11", "ack in reset", ack, 0);
        check(mem_we == 0, "R11", "mem_we in reset", mem_we, 0);
        @(negedge clk); rst_n = 1'b1;
        cyc(0, 0, 0, 8'h00);

        // R2 R3 R7: three bytes, upper bits of high byte ignored
        clr(); head(8'hA0, 8'hE1, 8'h23);
        send(8'hA0); send(8'hA1); send(8'hA2);
        cyc(0, 1, 0, 8'h00);
        wait_done();
        chk_mem(13'h0123, 8'hA0, "R2");
        chk_mem(13'h0124, 8'hA1, "R3");
        chk_mem(13'h0125, 8'hA2, "R3");
        chk_mem(13'h0122, -1, "R7");
        chk_mem(13'h0126, -1, "R7");
        check(busy_cnt == ERASE_CYC + WRITE_CYC, "R5", "busy length", busy_cnt,
              ERASE_CYC + WRITE_CYC);

        // R4: wrap at page end
        clr(); head(8'hA0, 8'h1F, 8'h5E);
        send(8'h11); send(8'h22); send(8'h33); send(8'h44);
        cyc(0, 1, 0, 8'h00);
        wait_done();
        chk_mem(13'h1F5E, 8'h11, "R4");
        chk_mem(13'h1F5F, 8'h22, "R4");
        chk_mem(13'h1F40, 8'h33, "R4");
        chk_mem(13'h1F41, 8'h44, "R4");
        chk_mem(13'h1F60, -1, "R4");
        chk_mem(13'h1F42, -1, "R7");

        // R4: 34 bytes overwrite offsets 0 and 1
        clr(); head(8'hA0, 8'h00, 8'h40);
        for (int i = 0; i < 34; i++) send(8'(i + 16));
        cyc(0, 1, 0, 8'h00);
        wait_done();
        chk_mem(13'h0040, 8'h30, "R4");
        chk_mem(13'h0041, 8'h31, "R4");
        chk_mem(13'h0042, 8'h12, "R4");
        chk_mem(13'h005F, 8'h2F, "R4");
        chk_mem(13'h0060, -1, "R4");

        // R8: read command
        clr(); head(8'hA1, 8'h01, 8'h00);
        send(8'h55);
        cyc(0, 1, 0, 8'h00);
        wait_done();
        check(seen_ack == 0, "R8", "ack after read cmd", seen_ack, 0);
        check(seen_busy == 0, "R8", "busy after read cmd", seen_busy, 0);
        check(dut_mem.size() == 0, "R8", "writes after read cmd", dut_mem.size(), 0);

        // R8: stop before data
        clr(); head(8'hA0, 8'h01, 8'h00);
        cyc(0, 1, 0, 8'h00);
        wait_done();
        check(seen_busy == 0, "R8", "busy after empty write", seen_busy, 0);

        // R1: device not selected
        clr(); dev_match = 1'b0;
        head(8'hA0, 8'h01, 8'h00);
        send(8'h66);
        cyc(0, 1, 0, 8'h00);
        wait_done();
        dev_match = 1'b1;
        check(seen_ack == 0, "R1", "ack with no match", seen_ack, 0);
        check(seen_busy == 0, "R1", "busy with no match", seen_busy, 0);

        // R10: restart discards earlier bytes
        clr(); head(8'hA0, 8'h02, 8'h00);
        send(8'h77); send(8'h78);
        head(8'hA0, 8'h02, 8'h10);
        send(8'h79);
        cyc(0, 1, 0, 8'h00);
        wait_done();
        chk_mem(13'h0200, -1, "R10");
        chk_mem(13'h0201, -1, "R10");
        chk_mem(13'h0210, 8'h79, "R10");

        // R9: traffic during busy is ignored
        clr(); head(8'hA0, 8'h03, 8'h00);
        send(8'h81);
        cyc(0, 1, 0, 8'h00);
        cyc(0, 0, 0, 8'h00);
        seen_ack = 0;
        head(8'hA0, 8'h04, 8'h00);
        send(8'h82);
        cyc(0, 1, 0, 8'h00);
        check(seen_ack == 0, "R9", "ack during busy", seen_ack, 0);
        wait_done();
        busy_cnt = 0;
        repeat (5) cyc(0, 0, 0, 8'h00);
        check(busy_cnt == 0, "R9", "no second cycle", busy_cnt, 0);
        chk_mem(13'h0300, 8'h81, "R9");
        chk_mem(13'h0400, -1, "R9");
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (20000) @(posedge clk);
                n_chk++; n_fail++;
                $display("FAIL R5 watchdog: actual=timeout expected=done");
            end
        join_any
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule